// File: doc/BRIEF.md
# Strided Read / Paired Write Memory Port

This block fronts a word-addressed storage array with 37-bit words. Four request streams come in, each with its own valid/ready handshake. The first carries read addresses, each with a stride and a count. The second carries write addresses. The third carries write data. The fourth carries packed burst descriptors. Every result leaves on one shared output stream, and a flag marks each entry as a read word or a write acknowledge.

A read request produces `count` words, taken from `start`, `start+stride`, `start+2*stride` and so on. A descriptor is the same kind of read with a stride of one. A write is carried out only when both a write address and a write data word are held. After the word is in storage, one acknowledge token goes out on the output. Addresses are reduced modulo the array depth. Only one read burst runs at a time. When a read word and an acknowledge compete for the output, the acknowledge wins the first such contest, and after that the two sources take turns.

Top module: `strided_mem_port`

## Requirements
- R1: After reset, `out_valid` is 0 and `rd_addr_ready`, `desc_ready`, `wr_addr_ready` and `wr_data_ready` are all 1.
- R2: A read request with count 1 returns one entry with `out_is_ack`=0 and `out_data` equal to the word stored at that address.
- R3: A write is stored only after both its address and its data have been accepted, in either order. Until then no acknowledge appears. After the store, exactly one entry with `out_is_ack`=1 and `out_data`=0 is emitted.
- R4: A descriptor word holds the start address in bits 36..6 and the burst length in bits 5..0. It returns that many words from consecutive addresses, in ascending order.
- R5: A read request with stride S and count N returns N read entries, in order, from start, start+S, ..., start+(N-1)*S.
- R6: A read request with count 0, or a descriptor with size 0, produces no output entry, and the request ports are ready again on the next cycle.
- R7: Addresses and address increments wrap modulo DEPTH (default 1024), so address DEPTH+k reads location k.
- R8: Once a burst of N>1 words is accepted, `rd_addr_ready` and `desc_ready` stay low until the cycle after its last address is issued.
- R9: When a read word and an acknowledge are both pending and the previous grant went to a read, the acknowledge goes out first. Grants then alternate between the two sources for as long as both have entries waiting.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_is_ack` hold their values and no entry is lost.
- R11: A read issued after the acknowledge of a write to the same address returns the newly written word.
- R12: With the output idle, an acknowledge becomes valid after the second rising edge that follows the write pair's acceptance. The first read word becomes valid after the third rising edge that follows a read request's acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr_valid | input | 1 | Read request valid |
| rd_addr_ready | output | 1 | Read request accepted when high with valid |
| rd_addr | input | 31 | Read start address |
| rd_stride | input | 31 | Address increment between burst words |
| rd_count | input | CNT_W (16) | Number of words to return |
| desc_valid | input | 1 | Descriptor valid |
| desc_ready | output | 1 | Descriptor accepted when high with valid |
| desc | input | 37 | Packed descriptor: address [36:6], size [5:0] |
| wr_addr_valid | input | 1 | Write address valid |
| wr_addr_ready | output | 1 | Write address can be taken |
| wr_addr | input | 31 | Write address |
| wr_data_valid | input | 1 | Write data valid |
| wr_data_ready | output | 1 | Write data can be taken |
| wr_data | input | 37 | Write data word |
| out_valid | output | 1 | Output entry valid |
| out_ready | input | 1 | Consumer takes the entry |
| out_data | output | 37 | Read word, or zero for an acknowledge |
| out_is_ack | output | 1 | 1 for a write acknowledge, 0 for a read word |

## Verification
An acknowledge is due two rising edges after the write pair is accepted: one edge to commit the store and one to load the output register. A read word is due three edges after the request is accepted, because the address register, the array read and the queue push each take one edge before the output register loads. The bench counts falling edges from the acceptance edge and samples `out_valid` just before and just after each due edge. Everywhere else the bench holds `out_ready` low and raises it only inside its receive task. Entries therefore wait in the output register rather than draining unseen, and every comparison is made against an entry that is stable at a falling edge.

// File: rtl/smp_pkg.sv
package smp_pkg;
  localparam int WORD_W = 37;
  localparam int ADDR_W = 31;
  localparam int SIZE_W = 6;

  typedef struct packed {
    logic [ADDR_W-1:0] start;
    logic [SIZE_W-1:0] len;
  } burst_desc_t;
endpackage

// File: rtl/smp_ram.sv
module smp_ram #(
  parameter int W     = 37,
  parameter int DEPTH = 1024,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [IW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/smp_burst_gen.sv
module smp_burst_gen
  import smp_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int CNT_W = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_start,
  input  logic [ADDR_W-1:0] rd_step,
  input  logic [CNT_W-1:0]  rd_len,
  input  logic              dsc_valid,
  output logic              dsc_ready,
  input  logic [WORD_W-1:0] dsc_word,
  input  logic              credit_ok,
  output logic              issue,
  output logic [IW-1:0]     issue_idx
);
  burst_desc_t     dsc;
  logic            busy;
  logic [IW-1:0]   cur, step;
  logic [CNT_W-1:0] left;
  logic            take_rd, take_dsc;

  assign dsc       = burst_desc_t'(dsc_word);
  assign rd_ready  = !busy;
  assign dsc_ready = !busy && !rd_valid;
  assign take_rd   = rd_valid && rd_ready;
  assign take_dsc  = dsc_valid && dsc_ready;
  assign issue     = busy && credit_ok;
  assign issue_idx = cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cur  <= '0;
      step <= '0;
      left <= '0;
    end else if (take_rd) begin
      cur  <= rd_start[IW-1:0];
      step <= rd_step[IW-1:0];
      left <= rd_len;
      busy <= (rd_len != '0);
    end else if (take_dsc) begin
      cur  <= dsc.start[IW-1:0];
      step <= IW'(1);
      left <= CNT_W'(dsc.len);
      busy <= (dsc.len != '0);
    end else if (issue) begin
      cur  <= cur + step;
      left <= left - CNT_W'(1);
      if (left == CNT_W'(1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/smp_rd_fifo.sv
module smp_rd_fifo #(
  parameter int W  = 37,
  parameter int QD = 4,
  localparam int PW = $clog2(QD),
  localparam int CW = $clog2(QD + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] level
);
  logic [W-1:0]  slot [QD];
  logic [PW-1:0] wp, rp;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(QD - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) slot[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      level <= level + CW'(push) - CW'(pop);
    end
  end

  assign dout = slot[rp];
endmodule

// File: rtl/smp_wr_pair.sv
module smp_wr_pair
  import smp_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int ACK_W = 4,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wa_valid,
  output logic              wa_ready,
  input  logic [ADDR_W-1:0] wa,
  input  logic              wd_valid,
  output logic              wd_ready,
  input  logic [WORD_W-1:0] wd,
  output logic              we,
  output logic [IW-1:0]     widx,
  output logic [WORD_W-1:0] wword,
  input  logic              ack_take,
  output logic              ack_pend
);
  logic              a_v, d_v;
  logic [IW-1:0]     a_q;
  logic [WORD_W-1:0] d_q;
  logic [ACK_W-1:0]  owed;

  assign wa_ready = !a_v;
  assign wd_ready = !d_v;
  assign we       = a_v && d_v && (owed != '1);
  assign widx     = a_q;
  assign wword    = d_q;
  assign ack_pend = (owed != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      a_v  <= 1'b0;
      d_v  <= 1'b0;
      a_q  <= '0;
      d_q  <= '0;
      owed <= '0;
    end else begin
      if (wa_valid && wa_ready) begin
        a_v <= 1'b1;
        a_q <= wa[IW-1:0];
      end else if (we) begin
        a_v <= 1'b0;
      end
      if (wd_valid && wd_ready) begin
        d_v <= 1'b1;
        d_q <= wd;
      end else if (we) begin
        d_v <= 1'b0;
      end
      owed <= owed + ACK_W'(we) - ACK_W'(ack_take);
    end
  end
endmodule

// File: rtl/smp_out_arb.sv
module smp_out_arb #(
  parameter int W = 37
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_avail,
  input  logic [W-1:0] rd_word,
  input  logic         ack_avail,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         out_is_ack,
  output logic         rd_pop,
  output logic         ack_take
);
  logic load, pick_ack, pick_rd, favor_ack;

  assign load     = !out_valid || out_ready;
  assign pick_ack = ack_avail && (!rd_avail || favor_ack);
  assign pick_rd  = rd_avail && !pick_ack;
  assign rd_pop   = load && pick_rd;
  assign ack_take = load && pick_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_is_ack <= 1'b0;
      favor_ack  <= 1'b1;
    end else if (load) begin
      out_valid <= pick_ack || pick_rd;
      if (pick_ack) begin
        out_data   <= '0;
        out_is_ack <= 1'b1;
        favor_ack  <= 1'b0;
      end else if (pick_rd) begin
        out_data   <= rd_word;
        out_is_ack <= 1'b0;
        favor_ack  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/strided_mem_port.sv
module strided_mem_port
  import smp_pkg::*;
#(
  parameter int DEPTH    = 1024,
  parameter int CNT_W    = 16,
  parameter int RQ_DEPTH = 4,
  parameter int ACK_W    = 4,
  localparam int IW      = $clog2(DEPTH),
  localparam int QCW     = $clog2(RQ_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_addr_valid,
  output logic              rd_addr_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] rd_stride,
  input  logic [CNT_W-1:0]  rd_count,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [WORD_W-1:0] desc,
  input  logic              wr_addr_valid,
  output logic              wr_addr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_data_valid,
  output logic              wr_data_ready,
  input  logic [WORD_W-1:0] wr_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_is_ack
);
  logic              issue, credit_ok, rd_back, rd_pop, ack_take, ack_pend, we;
  logic [IW-1:0]     issue_idx, widx;
  logic [WORD_W-1:0] wword, ram_q, q_head;
  logic [QCW-1:0]    q_level;

  // words already in the queue plus the one leaving the array must leave room
  assign credit_ok = (32'(q_level) + 32'(rd_back)) < RQ_DEPTH;

  always_ff @(posedge clk) begin
    if (rst) rd_back <= 1'b0;
    else     rd_back <= issue;
  end

  smp_burst_gen #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_gen (
    .clk(clk), .rst(rst),
    .rd_valid(rd_addr_valid), .rd_ready(rd_addr_ready),
    .rd_start(rd_addr), .rd_step(rd_stride), .rd_len(rd_count),
    .dsc_valid(desc_valid), .dsc_ready(desc_ready), .dsc_word(desc),
    .credit_ok(credit_ok), .issue(issue), .issue_idx(issue_idx)
  );

  smp_wr_pair #(.DEPTH(DEPTH), .ACK_W(ACK_W)) u_wr (
    .clk(clk), .rst(rst),
    .wa_valid(wr_addr_valid), .wa_ready(wr_addr_ready), .wa(wr_addr),
    .wd_valid(wr_data_valid), .wd_ready(wr_data_ready), .wd(wr_data),
    .we(we), .widx(widx), .wword(wword),
    .ack_take(ack_take), .ack_pend(ack_pend)
  );

  smp_ram #(.W(WORD_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(we), .waddr(widx), .wdata(wword),
    .re(issue), .raddr(issue_idx), .rdata(ram_q)
  );

  smp_rd_fifo #(.W(WORD_W), .QD(RQ_DEPTH)) u_q (
    .clk(clk), .rst(rst), .push(rd_back), .din(ram_q),
    .pop(rd_pop), .dout(q_head), .level(q_level)
  );

  smp_out_arb #(.W(WORD_W)) u_arb (
    .clk(clk), .rst(rst),
    .rd_avail(q_level != '0), .rd_word(q_head), .ack_avail(ack_pend),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_is_ack(out_is_ack), .rd_pop(rd_pop), .ack_take(ack_take)
  );
endmodule

// File: rtl/smp_checker.sv
module smp_checker #(
  parameter int WORD_W = 37,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_addr_valid,
  input logic              rd_addr_ready,
  input logic [CNT_W-1:0]  rd_count,
  input logic              desc_valid,
  input logic              desc_ready,
  input logic [WORD_W-1:0] desc,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              out_is_ack
);
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_is_ack)));

  assert_burst_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_valid && rd_addr_ready && (rd_count > CNT_W'(1))) |=> (!rd_addr_ready && !desc_ready));

  assert_zero_read_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_valid && rd_addr_ready && (rd_count == '0)) |=> rd_addr_ready);

  assert_zero_desc_R6: assert property (@(posedge clk) disable iff (rst)
    (desc_valid && desc_ready && (desc[5:0] == 6'd0)) |=> rd_addr_ready);

  assert_ack_word_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_is_ack) |-> (out_data == '0));
endmodule

bind strided_mem_port smp_checker #(.WORD_W(smp_pkg::WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst),
  .rd_addr_valid(rd_addr_valid), .rd_addr_ready(rd_addr_ready), .rd_count(rd_count),
  .desc_valid(desc_valid), .desc_ready(desc_ready), .desc(desc),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_is_ack(out_is_ack)
);

// File: tb/sim_strided_mem_port.sv
module sim_strided_mem_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_addr_valid = 0, desc_valid = 0, wr_addr_valid = 0, wr_data_valid = 0;
  logic        out_ready = 0;
  logic [30:0] rd_addr = '0, rd_stride = '0, wr_addr = '0;
  logic [15:0] rd_count = '0;
  logic [36:0] desc = '0, wr_data = '0;
  logic        rd_addr_ready, desc_ready, wr_addr_ready, wr_data_ready;
  logic        out_valid, out_is_ack;
  logic [36:0] out_data;

  int checks = 0;
  int errors = 0;
  logic [36:0] model [1024];

  always #2.5 clk = ~clk;

  strided_mem_port u0 (.*);

  localparam logic [67:0] VECS [8] = '{
    {31'd10,   37'h1_0000_000A}, {31'd11, 37'h0_ABCD_0011},
    {31'd12,   37'h1_5A5A_0012}, {31'd1023, 37'h0_FFFF_F3FF},
    {31'd1,    37'h1_0F0F_0001}, {31'd0,  37'h0_1234_5000},
    {31'd5,    37'h1_7777_0005}, {31'd300, 37'h0_3C3C_012C}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_wa(input logic [30:0] a);
    @(negedge clk);
    wr_addr_valid = 1; wr_addr = a;
    while (!wr_addr_ready) @(negedge clk);
    @(posedge clk); #1 wr_addr_valid = 0;
  endtask

  task automatic send_wd(input logic [36:0] d);
    @(negedge clk);
    wr_data_valid = 1; wr_data = d;
    while (!wr_data_ready) @(negedge clk);
    @(posedge clk); #1 wr_data_valid = 0;
  endtask

  task automatic send_wr(input logic [30:0] a, input logic [36:0] d);
    @(negedge clk);
    wr_addr_valid = 1; wr_addr = a; wr_data_valid = 1; wr_data = d;
    while (!(wr_addr_ready && wr_data_ready)) @(negedge clk);
    @(posedge clk); #1 wr_addr_valid = 0; wr_data_valid = 0;
    model[a[9:0]] = d;
  endtask

  task automatic send_rd(input logic [30:0] a, input logic [30:0] s, input logic [15:0] n);
    @(negedge clk);
    rd_addr_valid = 1; rd_addr = a; rd_stride = s; rd_count = n;
    while (!rd_addr_ready) @(negedge clk);
    @(posedge clk); #1 rd_addr_valid = 0;
  endtask

  task automatic send_desc(input logic [30:0] a, input logic [5:0] n);
    @(negedge clk);
    desc_valid = 1; desc = {a, n};
    while (!desc_ready) @(negedge clk);
    @(posedge clk); #1 desc_valid = 0;
  endtask

  task automatic get_out(output logic k, output logic [36:0] d);
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    k = out_is_ack; d = out_data;
    out_ready = 1;
    @(posedge clk); #1 out_ready = 0;
  endtask

  task automatic expect_rd(input string tag, input logic [36:0] e);
    logic k; logic [36:0] d;
    get_out(k, d);
    chk({tag, " kind"}, 64'(k), 64'(0));
    chk(tag, 64'(d), 64'(e));
  endtask

  task automatic expect_ack(input string tag);
    logic k; logic [36:0] d;
    get_out(k, d);
    chk({tag, " ack kind"}, 64'(k), 64'(1));
    chk({tag, " ack word"}, 64'(d), 64'(0));
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 out_valid", 64'(out_valid), 64'(0));
    chk("R1 rd_addr_ready", 64'(rd_addr_ready), 64'(1));
    chk("R1 desc_ready", 64'(desc_ready), 64'(1));
    chk("R1 wr_addr_ready", 64'(wr_addr_ready), 64'(1));
    chk("R1 wr_data_ready", 64'(wr_data_ready), 64'(1));

    // table walk: write, acknowledge, read back (R2, R3, R11)
    for (int i = 0; i < 8; i++) begin
      send_wr(VECS[i][67:37], VECS[i][36:0]);
      expect_ack("R3 table");
      send_rd(VECS[i][67:37], 31'd0, 16'd1);
      expect_rd("R2 table read", VECS[i][36:0]);
    end

    // R12 latency of an acknowledge
    send_wr(31'd40, 37'h1_4040_4040);
    repeat (2) @(negedge clk);
    chk("R12 ack early", 64'(out_valid), 64'(0));
    @(negedge clk);
    chk("R12 ack due", 64'(out_valid), 64'(1));
    expect_ack("R12");

    // R12 latency of a read word
    send_rd(31'd40, 31'd0, 16'd1);
    repeat (3) @(negedge clk);
    chk("R12 read early", 64'(out_valid), 64'(0));
    @(negedge clk);
    chk("R12 read due", 64'(out_valid), 64'(1));
    expect_rd("R12 read word", model[40]);

    // R3 address first, data later
    send_wa(31'd50);
    repeat (5) @(negedge clk);
    chk("R3 no ack without data", 64'(out_valid), 64'(0));
    send_wd(37'h0_5050_0050);
    model[50] = 37'h0_5050_0050;
    expect_ack("R3 addr-first");
    send_rd(31'd50, 31'd0, 16'd1);
    expect_rd("R3 addr-first stored", model[50]);

    // R3 data first, address later
    send_wd(37'h1_5151_0051);
    repeat (5) @(negedge clk);
    chk("R3 no ack without addr", 64'(out_valid), 64'(0));
    send_wa(31'd51);
    model[51] = 37'h1_5151_0051;
    expect_ack("R3 data-first");
    send_rd(31'd51, 31'd0, 16'd1);
    expect_rd("R3 data-first stored", model[51]);

    // R11 overwrite then read
    send_wr(31'd10, 37'h0_DEAD_0010);
    expect_ack("R11");
    send_rd(31'd10, 31'd0, 16'd1);
    expect_rd("R11 new data", 37'h0_DEAD_0010);

    // R4 descriptor burst
    send_desc(31'd10, 6'd3);
    for (int k = 0; k < 3; k++) expect_rd("R4 desc word", model[10 + k]);

    // R5 strided burst, R8 busy window
    for (int k = 0; k < 3; k++) begin
      send_wr(31'(20 + 3 * k), 37'h1_2000_0000 + 37'(k));
      expect_ack("R5 setup");
    end
    send_rd(31'd20, 31'd3, 16'd3);
    @(negedge clk);
    chk("R8 busy after accept", 64'(rd_addr_ready), 64'(0));
    chk("R8 desc blocked", 64'(desc_ready), 64'(0));
    repeat (2) @(negedge clk);
    chk("R8 busy before last", 64'(rd_addr_ready), 64'(0));
    @(negedge clk);
    chk("R8 free after last", 64'(rd_addr_ready), 64'(1));
    for (int k = 0; k < 3; k++) expect_rd("R5 stride word", model[20 + 3 * k]);

    // R7 wrap
    send_rd(31'd1023, 31'd2, 16'd2);
    expect_rd("R7 wrap first", model[1023]);
    expect_rd("R7 wrap second", model[1]);
    send_rd(31'd1029, 31'd0, 16'd1);
    expect_rd("R7 high address", model[5]);

    // R6 zero-length requests
    send_desc(31'd5, 6'd0);
    @(negedge clk);
    chk("R6 desc ready again", 64'(desc_ready), 64'(1));
    send_rd(31'd5, 31'd1, 16'd0);
    @(negedge clk);
    chk("R6 read ready again", 64'(rd_addr_ready), 64'(1));
    repeat (6) @(negedge clk);
    chk("R6 no output", 64'(out_valid), 64'(0));

    // R9 arbitration, R10 stall
    send_rd(31'd300, 31'd0, 16'd1);
    repeat (6) @(negedge clk);
    chk("R10 held valid", 64'(out_valid), 64'(1));
    chk("R10 held word", 64'(out_data), 64'(model[300]));
    send_rd(31'd20, 31'd3, 16'd2);
    send_wr(31'd60, 37'h0_6060_0060);
    send_wr(31'd61, 37'h1_6161_0061);
    repeat (10) @(negedge clk);
    chk("R10 still held", 64'(out_data), 64'(model[300]));
    expect_rd("R10 stalled word", model[300]);
    expect_ack("R9 ack first");
    expect_rd("R9 then read", model[20]);
    expect_ack("R9 ack again");
    expect_rd("R9 last read", model[23]);
    send_rd(31'd61, 31'd0, 16'd1);
    expect_rd("R11 after ack", model[61]);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule